// File: doc/BRIEF.md
# Flash Read-Protection Access Gate

This block sits between the instruction pipeline and the on-chip flash and rules on every flash access while read protection may be in force. Protection is in force only when a one-time-programmable enable fuse and a runtime activation bit are both set. The activation bit comes up set after reset. Software can clear or set it only under two conditions: the chip is in flash writing mode, or the write is issued by an instruction that was itself fetched from the flash.

Access requests arrive on a valid/ready channel. Each request carries an access kind, the fetch origin of the instruction that issued it, and the word the flash array would return. One cycle after acceptance, a registered verdict is offered on a second valid/ready channel. The verdict holds an allow flag, the returned data word, and a violation flag. Back-pressure rules: a request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high whenever the result slot is empty or is being drained in the same cycle. A presented result stays unchanged until `res_ready_i` is high at a clock edge. The current protection status is also driven as a plain output.

Top module: `flash_read_guard`

## Requirements
- R1: `prot_active_o` is 1 exactly when `otp_en_i` is 1 and the activation bit is 1. If either is 0, protection is off.
- R2: Reset sets the activation bit to 1, so a part with the fuse set leaves reset with protection on.
- R3: While protection is on, data reads (kind 0) and branch targets (kind 1) are denied when the issuing instruction was fetched outside the flash, and allowed when it was fetched inside. With protection off, both kinds are allowed from any origin.
- R4: Program (kind 2) and erase (kind 3) requests are denied whenever protection is on, whatever their origin, and allowed whenever it is off.
- R5: When writing mode is off, an activation-bit write is taken only if `act_wr_from_flash_i` is 1. From outside the flash it is dropped silently and the status does not change.
- R6: When writing mode is on, an activation-bit write is taken from any origin. A write that is taken changes the status from the next cycle.
- R7: An allowed data read returns `req_arr_data_i`. A denied data read returns all ones. Branch, program and erase verdicts return zero data.
- R8: `res_viol_o` is high for only the first cycle that a denied data-read verdict is presented. It is low for every other verdict.
- R9: A verdict appears one cycle after acceptance and is based on the protection status at the acceptance edge. While `res_ready_i` is low it holds unchanged, and `req_ready_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| otp_en_i | input | 1 | One-time-programmable protection enable fuse |
| wr_mode_i | input | 1 | Flash writing mode is active |
| act_wr_en_i | input | 1 | Write strobe for the activation bit |
| act_wr_val_i | input | 1 | Value written to the activation bit |
| act_wr_from_flash_i | input | 1 | Writing instruction was fetched from the flash |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Access request can be accepted |
| req_kind_i | input | 2 | 0 data read, 1 branch, 2 program, 3 erase |
| req_from_flash_i | input | 1 | Issuing instruction was fetched from the flash |
| req_arr_data_i | input | DATA_W | Word read from the flash array |
| res_valid_o | output | 1 | Verdict valid |
| res_ready_i | input | 1 | Consumer takes the verdict |
| res_allow_o | output | 1 | Access allowed |
| res_rdata_o | output | DATA_W | Returned data word |
| res_viol_o | output | 1 | Violation pulse for a denied data read |
| prot_active_o | output | 1 | Protection currently in force |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A write from outside the flash in standard mode. A gate that accepted it would let untrusted code switch protection off.
- The same write in writing mode. A gate that still filtered it by origin would lock out reprogramming from RAM.
- Program and erase requests issued from inside the flash while protected. A design that exempted flash-resident code here would allow self-modification.
- A stalled consumer with a denied read waiting. This catches a violation pulse that repeats every stalled cycle, a verdict that changes while held, and a request taken into an occupied slot.
- Clearing the fuse while the activation bit is still set, which shows whether the status wrongly depends on one bit alone.

// File: rtl/fgate_pkg.sv
package fgate_pkg;
  typedef enum logic [1:0] {
    ACC_READ   = 2'd0,
    ACC_BRANCH = 2'd1,
    ACC_PROG   = 2'd2,
    ACC_ERASE  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/fgate_prot_reg.sv
module fgate_prot_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic otp_en,
  input  logic wr_mode,
  input  logic wr_en,
  input  logic wr_val,
  input  logic wr_from_flash,
  output logic prot
);
  logic act_q;
  logic take;

  // writing mode opens the bit to any origin; standard mode only to flash code
  assign take = wr_en && (wr_mode || wr_from_flash);

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= 1'b1;
    else if (take) act_q <= wr_val;
  end

  assign prot = otp_en & act_q;

  // R5
  a_r5_outside_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mode && !wr_from_flash) |=> $stable(act_q));
  // R5
  a_r5_flash_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mode && wr_from_flash) |=> (act_q == $past(wr_val)));
  // R6
  a_r6_writing_mode_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode) |=> (act_q == $past(wr_val)));
endmodule

// File: rtl/fgate_judge.sv
module fgate_judge
  import fgate_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              prot,
  input  acc_kind_e         kind,
  input  logic              from_flash,
  input  logic [DATA_W-1:0] arr_data,
  output logic              allow,
  output logic [DATA_W-1:0] rdata,
  output logic              viol
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  always_comb begin
    allow = 1'b0;
    rdata = '0;
    viol  = 1'b0;
    unique case (kind)
      ACC_READ: begin
        allow = !prot || from_flash;
        rdata = allow ? arr_data : ALL_ONES;
        viol  = !allow;
      end
      ACC_BRANCH: allow = !prot || from_flash;
      ACC_PROG, ACC_ERASE: allow = !prot;
      default: allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/fgate_resp_stage.sv
module fgate_resp_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_allow,
  input  logic [DATA_W-1:0] in_rdata,
  input  logic              in_viol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_allow,
  output logic [DATA_W-1:0] out_rdata,
  output logic              out_viol
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_viol  <= 1'b0;
      out_allow <= 1'b0;
      out_rdata <= '0;
    end else begin
      out_viol <= load && in_viol;
      if (load) begin
        out_valid <= 1'b1;
        out_allow <= in_allow;
        out_rdata <= in_rdata;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  a_r9_held_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_allow) && $stable(out_rdata)));
  // R8
  a_r8_viol_only_on_denial: assert property (@(posedge clk) disable iff (!rst_n)
    out_viol |-> (out_valid && !out_allow));
  // R8
  a_r8_viol_single_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !out_viol);
endmodule

// File: rtl/flash_read_guard.sv
module flash_read_guard
  import fgate_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              otp_en_i,
  input  logic              wr_mode_i,
  input  logic              act_wr_en_i,
  input  logic              act_wr_val_i,
  input  logic              act_wr_from_flash_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic              req_from_flash_i,
  input  logic [DATA_W-1:0] req_arr_data_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              res_allow_o,
  output logic [DATA_W-1:0] res_rdata_o,
  output logic              res_viol_o,
  output logic              prot_active_o
);
  logic              prot;
  logic              j_allow;
  logic [DATA_W-1:0] j_rdata;
  logic              j_viol;

  fgate_prot_reg u_prot (
    .clk           (clk),
    .rst_n         (rst_n),
    .otp_en        (otp_en_i),
    .wr_mode       (wr_mode_i),
    .wr_en         (act_wr_en_i),
    .wr_val        (act_wr_val_i),
    .wr_from_flash (act_wr_from_flash_i),
    .prot          (prot)
  );

  fgate_judge #(.DATA_W(DATA_W)) u_judge (
    .prot       (prot),
    .kind       (acc_kind_e'(req_kind_i)),
    .from_flash (req_from_flash_i),
    .arr_data   (req_arr_data_i),
    .allow      (j_allow),
    .rdata      (j_rdata),
    .viol       (j_viol)
  );

  fgate_resp_stage #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid_i),
    .in_ready  (req_ready_o),
    .in_allow  (j_allow),
    .in_rdata  (j_rdata),
    .in_viol   (j_viol),
    .out_valid (res_valid_o),
    .out_ready (res_ready_i),
    .out_allow (res_allow_o),
    .out_rdata (res_rdata_o),
    .out_viol  (res_viol_o)
  );

  assign prot_active_o = prot;

  // R4
  a_r4_prog_erase_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && req_kind_i[1] && prot_active_o) |=> (res_valid_o && !res_allow_o));
  // R3
  a_r3_flash_code_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !req_kind_i[1] && req_from_flash_i) |=> (res_valid_o && res_allow_o));
  // R3
  a_r3_unprotected_open: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !prot_active_o) |=> res_allow_o);
endmodule

// File: tb/flash_read_guard_tb.sv
module flash_read_guard_tb;
  localparam int DW = 16;

  typedef struct {
    logic          allow;
    logic [DW-1:0] rdata;
    logic          viol;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic otp_en = 1'b1, wr_mode = 1'b0;
  logic aw_en = 1'b0, aw_val = 1'b0, aw_ff = 1'b0;
  logic req_valid = 1'b0, req_ready, req_ff = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [DW-1:0] req_data = '0;
  logic res_valid, res_ready = 1'b1, res_allow, res_viol, prot;
  logic [DW-1:0] res_rdata;

  int total = 0, bad = 0;
  logic act_m = 1'b1;
  logic fresh = 1'b1;
  exp_t q[$];

  always #5 clk = ~clk;

  flash_read_guard #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .otp_en_i(otp_en), .wr_mode_i(wr_mode),
    .act_wr_en_i(aw_en), .act_wr_val_i(aw_val), .act_wr_from_flash_i(aw_ff),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
    .req_from_flash_i(req_ff), .req_arr_data_i(req_data),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_allow_o(res_allow),
    .res_rdata_o(res_rdata), .res_viol_o(res_viol), .prot_active_o(prot)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // driver: called at a negedge; pushes the expected verdict
  task automatic send(input logic [1:0] kind, input logic ff, input logic [DW-1:0] d, input string tag);
    exp_t e;
    logic p;
    req_kind = kind; req_ff = ff; req_data = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    p = otp_en & act_m;
    e.tag = tag; e.rdata = '0; e.viol = 1'b0;
    if (kind[1]) e.allow = !p;
    else e.allow = !p || ff;
    if (kind == 2'd0) begin
      e.rdata = e.allow ? d : {DW{1'b1}};
      e.viol  = !e.allow;
    end
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic act_write(input logic mode, input logic ff, input logic v);
    wr_mode = mode; aw_en = 1'b1; aw_ff = ff; aw_val = v;
    if (mode || ff) act_m = v;
    @(negedge clk);
    aw_en = 1'b0; wr_mode = 1'b0;
  endtask

  // monitor: scoreboard compare
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (q.size() == 0) chk(1'b0, "R9 unexpected verdict", 1, 0);
        else begin
          e = q[0];
          chk(res_allow == e.allow, {e.tag, " allow"}, res_allow, e.allow);
          chk(res_rdata == e.rdata, {e.tag, " R7 data"}, res_rdata, e.rdata);
          if (fresh) chk(res_viol == e.viol, {e.tag, " R8 viol"}, res_viol, e.viol);
          else chk(res_viol == 1'b0, {e.tag, " R8 viol repeat"}, res_viol, 0);
          if (res_ready) begin
            void'(q.pop_front());
            fresh = 1'b1;
          end else fresh = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R1: fuse set, activation bit set by reset
    chk(prot == 1'b1, "R2 reset status", prot, 1);
    chk(res_valid == 1'b0, "R9 reset empty", res_valid, 0);
    chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);

    // R3 R4 R7 R8 protected
    send(2'd0, 1'b0, 16'h1234, "R3 read outside protected");
    send(2'd0, 1'b1, 16'hA5A5, "R3 read inside protected");
    send(2'd1, 1'b0, 16'h0000, "R3 branch outside protected");
    send(2'd1, 1'b1, 16'h0000, "R3 branch inside protected");
    send(2'd2, 1'b1, 16'h0000, "R4 program inside protected");
    send(2'd3, 1'b0, 16'h0000, "R4 erase outside protected");

    // R5 outside write in standard mode dropped
    act_write(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(prot == 1'b1, "R5 outside write dropped", prot, 1);
    send(2'd0, 1'b0, 16'h5555, "R5 read after dropped write");

    // R5 flash-origin write taken
    act_write(1'b0, 1'b1, 1'b0);
    chk(prot == 1'b0, "R5 flash write clears", prot, 0);
    send(2'd0, 1'b0, 16'h0F0F, "R3 read outside unprotected");
    send(2'd2, 1'b0, 16'h0000, "R4 program unprotected");
    send(2'd3, 1'b1, 16'h0000, "R4 erase unprotected");

    // R6 writing mode, outside origin
    act_write(1'b1, 1'b0, 1'b1);
    chk(prot == 1'b1, "R6 writing mode write sets", prot, 1);
    send(2'd1, 1'b0, 16'h0000, "R6 branch outside after set");

    // R1 fuse clear with activation bit set
    otp_en = 1'b0;
    @(negedge clk);
    chk(prot == 1'b0, "R1 fuse clear", prot, 0);
    send(2'd0, 1'b0, 16'hBEEF, "R1 read outside fuse clear");
    otp_en = 1'b1;
    @(negedge clk);
    chk(prot == 1'b1, "R1 both set", prot, 1);

    // R9 R8 stall with denied read pending
    @(posedge clk); #1 res_ready = 1'b0;
    @(negedge clk);
    send(2'd0, 1'b0, 16'h7777, "R9 stalled denied read");
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b0, "R9 ready low while full", req_ready, 0);
    fork
      send(2'd0, 1'b1, 16'h2222, "R9 read after stall");
      begin
        repeat (2) @(negedge clk);
        @(posedge clk); #1 res_ready = 1'b1;
      end
    join
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R9 all verdicts drained", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule